// File: doc/BRIEF.md
# Byte-wide stack push/pop sequencer

This block moves 16-bit values between a processor's registers and a byte-wide memory through a downward-growing stack. It keeps the stack pointer itself. A single command can push a register pair, pop a register pair, call a subroutine, return from one, or make a restart call to one of eight fixed vectors. Each 16-bit value crosses the memory port as two byte transfers in a fixed order. A push decrements the pointer before each write and sends the high byte first. A pop reads the low byte first and increments the pointer after each read.

The register side presents a command with a 16-bit operand and the address of the next instruction. It gets back the popped value or the new program counter. A separate load input places a new value in the stack pointer, which sets where the stack begins. Every memory transfer waits for the memory's ready signal. The block reports busy from the cycle after it accepts a command until the command has finished.

Top module: `stk_seq`

## Requirements
- R1: While rst is high, and in the cycle after it falls, sp equals the SP_RESET parameter (default 0000h). In that same window pc_out and pop_data are 0000h, busy and done are low, and mem_rd and mem_wr are low.
- R2: When the block is idle and sp_load is high, sp takes sp_load_val at the next clock edge. This load takes precedence over a command in the same cycle. While busy is high, sp_load has no effect.
- R3: Push (cmd_op = 0) writes cmd_data[15:8] to address sp-1 and then cmd_data[7:0] to address sp-2. The stack pointer ends at sp-2.
- R4: Pop (cmd_op = 1) reads the low byte at address sp and then the high byte at address sp+1. pop_data becomes {high, low} and the stack pointer ends at sp+2.
- R5: Call (cmd_op = 2) pushes cmd_pc in the same way that R3 pushes a value. It then sets pc_out to cmd_data.
- R6: Return (cmd_op = 3) pops a value in the same way as R4 and places it in pc_out. pop_data keeps its previous value.
- R7: Restart (cmd_op = 4) pushes cmd_pc in the same way as R3. It then sets pc_out to cmd_data[2:0] times 8, for example 0018h for index 3. cmd_data[15:3] is ignored.
- R8: Each byte transfer asserts exactly one of mem_rd and mem_wr. The strobe, mem_addr and mem_wdata stay unchanged until a cycle in which mem_ready is high, and only then does the sequence move to its next transfer.
- R9: busy rises in the cycle after a command is accepted and falls together with a one-cycle done pulse, one cycle after the last transfer completes. A command presented while busy is high is ignored.
- R10: The stack pointer wraps modulo 2^16. A decrement from 0000h gives FFFFh, and an increment from FFFFh gives 0000h.
- R11: A cmd_op value of 5, 6 or 7 is ignored. No strobe is issued, busy stays low, and sp is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_op | input | 3 | 0 push, 1 pop, 2 call, 3 return, 4 restart |
| cmd_data | input | 16 | Value to push, call target, or restart index in bits 2:0 |
| cmd_pc | input | 16 | Address of the next instruction, pushed by call and restart |
| sp_load | input | 1 | Load the stack pointer directly |
| sp_load_val | input | 16 | New stack pointer value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| sp | output | 16 | Current stack pointer |
| pc_out | output | 16 | Program counter set by call, return and restart |
| pop_data | output | 16 | Value returned by the last pop |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Memory accepts or returns the current byte |

## Verification
A wrong stack pointer shows up as soon as the next transfer starts: mem_addr is off, and the sp port is wrong when done rises. A swapped byte order or a misplaced pre-decrement puts the wrong byte at an address. That mistake shows at the ports only when a later pop returns the value, or when the bench compares its memory image at done. A sequencer state that skips the ready wait shows within one transfer, as a strobe or address that changes while mem_ready is low. A stuck state shows as a done pulse that never comes.

// File: rtl/stk_pkg.sv
package stk_pkg;
    parameter int BYTE_W    = 8;
    parameter int WORD_W    = 2 * BYTE_W;
    parameter int IDX_W     = 3;
    parameter int VEC_SHIFT = 3;

    typedef enum logic [2:0] {
        OP_PUSH    = 3'd0,
        OP_POP     = 3'd1,
        OP_CALL    = 3'd2,
        OP_RET     = 3'd3,
        OP_RESTART = 3'd4
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_LO,
        ST_RD_HI
    } stk_state_e;

    function automatic logic op_known(logic [2:0] op);
        return op <= 3'd4;
    endfunction

    function automatic logic op_writes(logic [2:0] op);
        return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_RESTART);
    endfunction

    function automatic logic [WORD_W-1:0] restart_vector(logic [IDX_W-1:0] idx);
        return WORD_W'(idx) << VEC_SHIFT;
    endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter logic [WORD_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              dec,
    input  logic              inc,
    output logic [WORD_W-1:0] sp
);
    always_ff @(posedge clk) begin
        if (rst)       sp <= SP_RESET;
        else if (load) sp <= load_val;
        else if (dec)  sp <= sp - 1'b1;
        else if (inc)  sp <= sp + 1'b1;
    end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       sp_load,
    input  logic       mem_ready,
    output logic       accept,
    output logic       load_en,
    output logic       busy,
    output logic       wr,
    output logic       rd,
    output logic       hi,
    output logic       dec,
    output logic       inc,
    output logic       rd_lo_take,
    output logic       finish,
    output stk_op_e    op_q
);
    stk_state_e state, state_nx;
    logic       idle;

    assign idle       = (state == ST_IDLE);
    assign load_en    = idle && sp_load;
    assign accept     = idle && !sp_load && cmd_valid && op_known(cmd_op);
    assign busy       = !idle;
    assign wr         = (state == ST_WR_HI) || (state == ST_WR_LO);
    assign rd         = (state == ST_RD_LO) || (state == ST_RD_HI);
    assign hi         = (state == ST_WR_HI) || (state == ST_RD_HI);
    assign dec        = wr && mem_ready;
    assign inc        = rd && mem_ready;
    assign rd_lo_take = (state == ST_RD_LO) && mem_ready;
    assign finish     = mem_ready && ((state == ST_WR_LO) || (state == ST_RD_HI));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = op_writes(cmd_op) ? ST_WR_HI : ST_RD_LO;
            ST_WR_HI: if (mem_ready) state_nx = ST_WR_LO;
            ST_WR_LO: if (mem_ready) state_nx = ST_IDLE;
            ST_RD_LO: if (mem_ready) state_nx = ST_RD_HI;
            ST_RD_HI: if (mem_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= OP_PUSH;
        end else begin
            state <= state_nx;
            if (accept) op_q <= stk_op_e'(cmd_op);
        end
    end
endmodule

// File: rtl/stk_data.sv
module stk_data
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [WORD_W-1:0] cmd_pc,
    input  logic              hi,
    input  logic              rd_lo_take,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] wbyte,
    output logic [WORD_W-1:0] target_q,
    output logic [WORD_W-1:0] popped
);
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            target_q <= '0;
            lo_q     <= '0;
        end else begin
            if (accept) begin
                word_q   <= (cmd_op == OP_PUSH) ? cmd_data : cmd_pc;
                target_q <= cmd_data;
            end
            if (rd_lo_take) lo_q <= mem_rdata;
        end
    end

    assign wbyte  = hi ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
    assign popped = {mem_rdata, lo_q};
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter logic [WORD_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [WORD_W-1:0] cmd_pc,
    input  logic              sp_load,
    input  logic [WORD_W-1:0] sp_load_val,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] sp,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] pop_data,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready
);
    logic              accept, load_en, hi, dec, inc, rd_lo_take, finish;
    stk_op_e           op_q;
    logic [WORD_W-1:0] target_q, popped;

    stk_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sp_load(sp_load), .mem_ready(mem_ready), .accept(accept),
        .load_en(load_en), .busy(busy), .wr(mem_wr), .rd(mem_rd), .hi(hi),
        .dec(dec), .inc(inc), .rd_lo_take(rd_lo_take), .finish(finish),
        .op_q(op_q)
    );

    stk_ptr #(.SP_RESET(SP_RESET)) u_ptr (
        .clk(clk), .rst(rst), .load(load_en), .load_val(sp_load_val),
        .dec(dec), .inc(inc), .sp(sp)
    );

    stk_data u_data (
        .clk(clk), .rst(rst), .accept(accept), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_pc(cmd_pc), .hi(hi),
        .rd_lo_take(rd_lo_take), .mem_rdata(mem_rdata), .wbyte(mem_wdata),
        .target_q(target_q), .popped(popped)
    );

    // Writes go to the slot below the pointer; reads come from the pointer.
    assign mem_addr = mem_wr ? (sp - 1'b1) : sp;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_out   <= '0;
            pop_data <= '0;
            done     <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                unique case (op_q)
                    OP_POP:     pop_data <= popped;
                    OP_RET:     pc_out   <= popped;
                    OP_CALL:    pc_out   <= target_q;
                    OP_RESTART: pc_out   <= restart_vector(target_q[IDX_W-1:0]);
                    default:    ;
                endcase
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R8
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R8
    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_ready) |=> (sp == $past(mem_addr))); // R3
    AST_POP_POSTINC: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_ready) |=> (sp == WORD_W'($past(mem_addr) + 1'b1))); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr)); // R11
endmodule

// File: tb/test_stk_seq.sv
module test_stk_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = '0, cmd_pc = '0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_load_val = '0;
    logic        busy, done, mem_rd, mem_wr;
    logic [15:0] sp, pc_out, pop_data, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int strobe_cnt = 0;
    logic [7:0] bmem [logic [15:0]];
    logic [15:0] exp_sp, exp_pc, exp_pop;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_seq i_stk_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_pc(cmd_pc), .sp_load(sp_load),
        .sp_load_val(sp_load_val), .busy(busy), .done(done), .sp(sp),
        .pc_out(pc_out), .pop_data(pop_data), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] rd_byte(logic [15:0] a);
        if (bmem.exists(a)) return bmem[a];
        return 8'h00;
    endfunction

    // Memory model: decides ready for the coming edge and commits the write it will see.
    always @(negedge clk) begin
        if (mem_rd || mem_wr) strobe_cnt++;
        mem_ready = ($urandom_range(0, 2) != 0);
        if (mem_wr && mem_ready) bmem[mem_addr] = mem_wdata;
        mem_rdata = rd_byte(mem_addr);
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) chk("R9 timeout", 16'd0, 16'd1);
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] d, input logic [15:0] p);
        cmd_op = op; cmd_data = d; cmd_pc = p; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 busy after accept", {15'd0, busy}, 16'd1);
        wait_done();
    endtask

    task automatic load_sp(input logic [15:0] v);
        sp_load = 1'b1; sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
        exp_sp = v;
        chk("R2 sp load", sp, exp_sp);
    endtask

    // Expected results of one command, from the requirements and the bench memory.
    task automatic run_op(input logic [2:0] op, input logic [15:0] d, input logic [15:0] p);
        logic [15:0] s = exp_sp;
        logic [15:0] wv = (op == 3'd0) ? d : p;
        if (op == 3'd1 || op == 3'd3) begin
            logic [15:0] v = {rd_byte(s + 16'd1), rd_byte(s)};
            issue(op, d, p);
            exp_sp = s + 16'd2;
            if (op == 3'd1) exp_pop = v; else exp_pc = v;
            chk("R4 pop sp", sp, exp_sp);
            chk("R4 pop_data", pop_data, exp_pop);
            chk("R6 return pc", pc_out, exp_pc);
        end else begin
            issue(op, d, p);
            exp_sp = s - 16'd2;
            if (op == 3'd2) exp_pc = d;
            if (op == 3'd4) exp_pc = {10'd0, d[2:0], 3'd0};
            chk("R3 push sp", sp, exp_sp);
            chk("R3 high byte at sp-1", {8'd0, rd_byte(s - 16'd1)}, {8'd0, wv[15:8]});
            chk("R3 low byte at sp-2", {8'd0, rd_byte(s - 16'd2)}, {8'd0, wv[7:0]});
            chk("R5 R7 pc", pc_out, exp_pc);
        end
        @(negedge clk);
        chk("R9 done one cycle", {15'd0, done}, 16'd0);
        chk("R9 busy low", {15'd0, busy}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sc;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk("R1 sp reset", sp, 16'h0000);
        chk("R1 busy reset", {15'd0, busy}, 16'd0);
        chk("R1 strobes reset", {14'd0, mem_rd, mem_wr}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sp after reset", sp, 16'h0000);
        chk("R1 pc after reset", pc_out, 16'h0000);
        chk("R1 pop after reset", pop_data, 16'h0000);
        chk("R1 done after reset", {15'd0, done}, 16'd0);
        exp_sp = 16'h0000; exp_pc = '0; exp_pop = '0;

        // R3 R4 round trip
        load_sp(16'h4000);
        run_op(3'd0, 16'h1234, 16'h0);
        run_op(3'd1, 16'h0, 16'h0);
        chk("R4 round trip", pop_data, 16'h1234);

        // R5 R6 call and return
        run_op(3'd2, 16'h2222, 16'h1003);
        chk("R5 call target", pc_out, 16'h2222);
        run_op(3'd3, 16'h0, 16'h0);
        chk("R6 return address", pc_out, 16'h1003);

        // R7 restart vectors, upper index bits ignored
        run_op(3'd4, 16'hFFF3, 16'h0456);
        chk("R7 index 3 vector", pc_out, 16'h0018);
        run_op(3'd4, 16'h0007, 16'h0789);
        chk("R7 index 7 vector", pc_out, 16'h0038);

        // R10 wrap both ways
        load_sp(16'h0001);
        run_op(3'd0, 16'hABCD, 16'h0);
        chk("R10 decrement wrap", sp, 16'hFFFF);
        chk("R10 high byte at 0000", {8'd0, rd_byte(16'h0000)}, 16'h00AB);
        run_op(3'd1, 16'h0, 16'h0);
        chk("R10 increment wrap", pop_data, 16'hABCD);

        // R2 R9 inputs ignored while busy
        cmd_op = 3'd0; cmd_data = 16'h5A5A; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        sp_load = 1'b1; sp_load_val = 16'h7777;
        cmd_valid = 1'b1; cmd_op = 3'd1;
        @(negedge clk);
        sp_load = 1'b0; cmd_valid = 1'b0;
        wait_done();
        exp_sp = exp_sp - 16'd2;
        chk("R2 load ignored while busy", sp, exp_sp);
        @(negedge clk);
        chk("R9 command ignored while busy", {15'd0, busy}, 16'd0);
        chk("R9 sp after ignored command", sp, exp_sp);

        // R2 load wins over command in same cycle
        sp_load = 1'b1; sp_load_val = 16'h3000; cmd_valid = 1'b1; cmd_op = 3'd0;
        @(negedge clk);
        sp_load = 1'b0; cmd_valid = 1'b0;
        @(negedge clk);
        exp_sp = 16'h3000;
        chk("R2 load precedence sp", sp, exp_sp);
        chk("R2 load precedence busy", {15'd0, busy}, 16'd0);

        // R11 unknown codes
        for (int k = 5; k < 8; k++) begin
            sc = strobe_cnt;
            cmd_op = 3'(k); cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk("R11 busy", {15'd0, busy}, 16'd0);
            chk("R11 sp", sp, exp_sp);
            chk("R11 strobes", 16'(strobe_cnt - sc), 16'd0);
        end

        // Constrained random mix; R8 byte-level ready waits are random throughout
        for (int i = 0; i < 80; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 4));
            if ($urandom_range(0, 9) == 0) load_sp(16'($urandom));
            run_op(op, 16'($urandom), 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule